// File: doc/BRIEF.md
# Quadrature Clock Pair Generator

The block makes two clocks, `q_clk` and `e_clk`, from a reference clock. Both have the same frequency and an exact 50% duty cycle. They share one up-counter. The counter runs from zero to `half_cnt - 1` and then wraps. Each output has its own compare value and flips every time the counter reaches that value. So each output period is `2 * half_cnt` reference cycles. The position of each output's edges is set by its compare value, not by a duty setting. `e_clk` trails `q_clk` by `cmp_e - cmp_q` cycles. A spacing of `half_cnt / 2` puts the two clocks a quarter period apart, with Q leading.

A rising `enable` starts a fixed arming sequence. The sequence captures the three settings, holds both outputs low, holds the counter at zero, and then lets the counter run. Because of this sequence, the first edge on each output is always a rising edge, and Q cannot come up inverted and lag E. Dropping `enable` stops the block at once: both outputs go low and the counter parks at zero. A configuration that cannot work is refused and the outputs stay low.

Top module: `quad_clk_gen`

## Requirements
- R1: While `rst_n` is low, and afterwards while `enable` stays low, both `q_clk` and `e_clk` are 0.
- R2: The first rising clock edge with `enable` high captures `half_cnt`, `cmp_q` and `cmp_e` (arming). On the edge after that, the counter starts at 0. Through both edges the outputs stay 0.
- R3: While running, the counter steps from 0 to `half_cnt - 1` and then wraps to 0. Each output holds every level for exactly `half_cnt` cycles, so its duty cycle is exactly 50%.
- R4: Counting edges from the first edge after the counter starts (edge 1), an output first goes to 1 at edge `cmp + 1`. It then flips again every `half_cnt` edges. The first change on each output after a start is therefore a rise to 1.
- R5: `e_clk` copies `q_clk` delayed by `cmp_e - cmp_q` cycles. Example: with `half_cnt` 84, `cmp_q` 21 and `cmp_e` 63, Q is high from edge 22 through edge 105, and E is high from edge 64 through edge 147, a quarter-period lag.
- R6: If `enable` is low at a clock edge while running, both outputs are 0 after that edge. They stay 0, with the counter parked at 0, until a new start.
- R7: A capture with `half_cnt` = 0, or with either compare value at or above `half_cnt`, is refused. Both outputs stay 0 until `enable` goes low and a later start captures a valid set.
- R8: Changes on `half_cnt`, `cmp_q` and `cmp_e` after capture have no effect on the running outputs.
- R9: A stop wins over a compare match in the same cycle. The output that would have flipped is 0 after that edge.
- R10: When `cmp_q` equals `cmp_e`, the two outputs are identical on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to start and keep running; low stops |
| half_cnt | input | CNT_W | Half of the output period, in reference cycles |
| cmp_q | input | CNT_W | Counter value at which `q_clk` flips |
| cmp_e | input | CNT_W | Counter value at which `e_clk` flips |
| q_clk | output | 1 | Leading 50% clock |
| e_clk | output | 1 | Trailing 50% clock |

## Verification
A stop request can arrive in the same cycle that the counter matches a compare value. Toggling and stopping then both try to set the output's next level. The bench provokes this on purpose: it drops `enable` exactly in the cycle where the counter equals `cmp_q`, just before Q would rise. It then judges that Q and E are both 0 after that edge and stay 0. A second overlap arises when both compare values are equal, so both channels flip on the same edge. Random settings with equal compares check that the two outputs never differ.

// File: rtl/qcg_pkg.sv
package qcg_pkg;

  typedef logic [31:0] qcg_word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } qcg_state_e;

  // A usable setting needs a nonzero half period and both compares inside it.
  function automatic logic cfg_valid(input qcg_word_t half,
                                     input qcg_word_t cq,
                                     input qcg_word_t ce);
    return (half != '0) && (cq < half) && (ce < half);
  endfunction

  // Counter successor with wrap at half-1.
  function automatic qcg_word_t next_count(input qcg_word_t cnt,
                                           input qcg_word_t half);
    return (cnt + 32'd1 >= half) ? '0 : cnt + 32'd1;
  endfunction

endpackage

// File: rtl/qcg_sequencer.sv
module qcg_sequencer
  import qcg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [CNT_W-1:0]           half_in,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0]           half_lat,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_lat,
  output logic                       running,
  output logic                       arming,
  output logic                       cfg_ok,
  output logic                       keep
);

  qcg_state_e state;
  logic       all_ok;

  always_comb begin
    all_ok = 1'b1;
    for (int i = 0; i < int'(N_CH); i++) begin
      all_ok = all_ok & cfg_valid(qcg_word_t'(half_lat),
                                  qcg_word_t'(cmp_lat[i]),
                                  qcg_word_t'(cmp_lat[i]));
    end
  end

  assign cfg_ok  = all_ok;
  assign running = (state == ST_RUN);
  assign arming  = (state == ST_ARM);
  assign keep    = running && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half_lat <= '0;
      cmp_lat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (enable) begin
          half_lat <= half_in;
          cmp_lat  <= cmp_in;
          state    <= ST_ARM;
        end
        ST_ARM: begin
          if (!enable)     state <= ST_IDLE;
          else if (cfg_ok) state <= ST_RUN;
          else             state <= ST_HOLD;
        end
        ST_RUN:  if (!enable) state <= ST_IDLE;
        ST_HOLD: if (!enable) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/qcg_counter.sv
module qcg_counter
  import qcg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep,
  input  logic [CNT_W-1:0] half_lat,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!keep) cnt <= '0;
    else            cnt <= CNT_W'(next_count(qcg_word_t'(cnt), qcg_word_t'(half_lat)));
  end

endmodule

// File: rtl/qcg_toggle_ch.sv
module qcg_toggle_ch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             level
);

  assign hit = keep && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= 1'b0;
    else if (!keep) level <= 1'b0;
    else if (hit)   level <= ~level;
  end

endmodule

// File: rtl/quad_clk_gen.sv
module quad_clk_gen #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] half_cnt,
  input  logic [CNT_W-1:0] cmp_q,
  input  logic [CNT_W-1:0] cmp_e,
  output logic             q_clk,
  output logic             e_clk
);

  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0][CNT_W-1:0] cmp_in;
  logic [N_CH-1:0][CNT_W-1:0] cmp_lat;
  logic [CNT_W-1:0]           half_lat;
  logic [CNT_W-1:0]           cnt;
  logic [N_CH-1:0]            hit;
  logic [N_CH-1:0]            level;
  logic                       running, arming, cfg_ok, keep;
  logic                       hit_q, hit_e;

  assign cmp_in[0] = cmp_q;
  assign cmp_in[1] = cmp_e;

  qcg_sequencer #(.CNT_W(CNT_W), .N_CH(N_CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .half_in(half_cnt), .cmp_in(cmp_in),
    .half_lat(half_lat), .cmp_lat(cmp_lat),
    .running(running), .arming(arming), .cfg_ok(cfg_ok), .keep(keep)
  );

  qcg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .keep(keep), .half_lat(half_lat), .cnt(cnt)
  );

  for (genvar g = 0; g < int'(N_CH); g++) begin : g_ch
    qcg_toggle_ch #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .keep(keep), .cnt(cnt),
      .cmp(cmp_lat[g]), .hit(hit[g]), .level(level[g])
    );
  end

  assign hit_q = hit[0];
  assign hit_e = hit[1];
  assign q_clk = level[0];
  assign e_clk = level[1];

endmodule

// File: rtl/qcg_checker.sv
module qcg_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             running,
  input logic             arming,
  input logic             cfg_ok,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] half_lat,
  input logic             hit_q,
  input logic             hit_e,
  input logic             q_clk,
  input logic             e_clk
);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!q_clk && !e_clk));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < half_lat));

  // R4
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (!q_clk && !e_clk && cnt == '0));

  // R4
  q_toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (q_clk != $past(q_clk))) |-> $past(hit_q));

  // R5
  e_toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && (e_clk != $past(e_clk))) |-> $past(hit_e));

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !enable) |=> (!running && !q_clk && !e_clk));

  // R7
  reject_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arming && !cfg_ok) |=> !running);

endmodule

bind quad_clk_gen qcg_checker #(.CNT_W(CNT_W)) u_qcg_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
  .arming(arming), .cfg_ok(cfg_ok), .cnt(cnt), .half_lat(half_lat),
  .hit_q(hit_q), .hit_e(hit_e), .q_clk(q_clk), .e_clk(e_clk)
);

// File: tb/quad_clk_gen_test.sv
`timescale 1ns/1ps
module quad_clk_gen_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [CNT_W-1:0] half_cnt = '0;
  logic [CNT_W-1:0] cmp_q = '0;
  logic [CNT_W-1:0] cmp_e = '0;
  logic             q_clk, e_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  quad_clk_gen #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_cnt(half_cnt),
    .cmp_q(cmp_q), .cmp_e(cmp_e), .q_clk(q_clk), .e_clk(e_clk)
  );

  // Expected level after edge n of the run (edge 0 = counter start).
  function automatic logic exp_level(int n, int cmpv, int half);
    if (n <= cmpv) return 1'b0;
    return (((n - 1 - cmpv) / half) % 2) == 0;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Start with given settings; returns at the negedge right after counter start (n=0).
  task automatic start_run(int half, int cq, int ce);
    half_cnt = CNT_W'(half);
    cmp_q    = CNT_W'(cq);
    cmp_e    = CNT_W'(ce);
    enable   = 1'b1;
    step();
    check("R2", q_clk, 1'b0, "q during arm");
    check("R2", e_clk, 1'b0, "e during arm");
    step();
  endtask

  task automatic stop_run();
    enable = 1'b0;
    step();
    check("R6", q_clk, 1'b0, "q after stop");
    check("R6", e_clk, 1'b0, "e after stop");
  endtask

  // Run n edges and compare; optionally scramble inputs (R8).
  task automatic follow(int half, int cq, int ce, int edges, bit scramble, string req);
    for (int n = 0; n <= edges; n++) begin
      check(req, q_clk, exp_level(n, cq, half), "q level");
      check(req, e_clk, exp_level(n, ce, half), "e level");
      if (cq == ce) check("R10", q_clk, e_clk, "equal compares");
      if (scramble) begin
        half_cnt = CNT_W'($urandom_range(0, 60));
        cmp_q    = CNT_W'($urandom_range(0, 60));
        cmp_e    = CNT_W'($urandom_range(0, 60));
      end
      if (n < edges) step();
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int half, cq, ce;
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R1", q_clk, 1'b0, "q in reset");
    check("R1", e_clk, 1'b0, "e in reset");
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      check("R1", q_clk | e_clk, 1'b0, "outputs idle");
    end

    // R5: quarter-period example, 168-cycle period
    start_run(84, 21, 63);
    follow(84, 21, 63, 180, 1'b0, "R5");
    stop_run();

    // R3/R4: second quarter example
    start_run(42, 10, 31);
    follow(42, 10, 31, 100, 1'b0, "R3");
    stop_run();

    // R8: inputs scrambled while running
    start_run(12, 3, 9);
    follow(12, 3, 9, 60, 1'b1, "R8");
    stop_run();

    // R6: stays low and restarts cleanly
    for (int i = 0; i < 10; i++) begin
      step();
      check("R6", q_clk | e_clk, 1'b0, "stay low after stop");
    end

    // R9: stop in the cycle the counter equals cmp_q
    start_run(8, 5, 6);
    for (int n = 0; n < 5; n++) step();
    enable = 1'b0;
    step();
    check("R9", q_clk, 1'b0, "q stop beats match");
    check("R9", e_clk, 1'b0, "e stop beats match");
    step();
    check("R9", q_clk | e_clk, 1'b0, "still low");

    // R7: refused settings
    start_run(10, 10, 2);
    for (int n = 0; n < 30; n++) begin
      check("R7", q_clk | e_clk, 1'b0, "compare at half refused");
      step();
    end
    enable = 1'b0;
    step();
    start_run(0, 0, 0);
    for (int n = 0; n < 10; n++) begin
      check("R7", q_clk | e_clk, 1'b0, "zero half refused");
      step();
    end
    enable = 1'b0;
    step();
    start_run(10, 0, 9);
    follow(10, 0, 9, 45, 1'b0, "R7");
    stop_run();

    // R4: half of one, fastest toggling
    start_run(1, 0, 0);
    follow(1, 0, 0, 8, 1'b0, "R4");
    stop_run();

    // R10 and random cases
    for (int k = 0; k < 25; k++) begin
      half = $urandom_range(1, 40);
      cq   = $urandom_range(0, half - 1);
      ce   = (k % 5 == 0) ? cq : $urandom_range(0, half - 1);
      start_run(half, cq, ce);
      follow(half, cq, ce, 3 * half + 5, k[0], "R3");
      stop_run();
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule